// File: doc/BRIEF.md
# Gated Dual-Channel Frequency Counter

This block measures the rate of two slow digital inputs: an oscillator signal that has already been divided by four outside the block, and an external reference signal that arrives undivided. Both inputs are sampled in the domain of a steady reference clock (24 MHz in the intended system). A free-running gate timer divides that clock into fixed measurement periods, each one second long at the default setting. During most of a period each channel counts the rising edges it sees.

At the start of every period a short fixed sequence runs. It closes the gate, publishes both totals as high and low 16-bit result words, clears the counters and reopens the gate. Software reading the results can raise a hold flag. While the flag is high, the words published last stay in place, and the counters keep being cleared and reused every period.

The two inputs are asynchronous to the reference clock. For each transition to be seen, each must stay high and stay low for at least one reference-clock cycle. Arithmetic on the totals, such as the frequency itself or the prescaler factor, belongs to the software that reads them.

Top module: `freq_gate_meter`

## Requirements
- R1: The gate timer steps once per clock from 0 to GATE_LAST and then returns to 0, so a measurement period is GATE_LAST+1 cycles (24000006 by default). The result words change only at the clock edge where the timer reads 1.
- R2: A synchronised rising edge adds to its channel's count only at the clock edges where the timer reads 5 through GATE_LAST, or 0. An edge that reaches the counter at timer values 1 to 4 is lost.
- R3: At the timer-1 edge, if hold is low, each channel's count is published. The high word takes count bits [2*HALF_W-1:HALF_W] and the low word takes bits [HALF_W-1:0].
- R4: If hold_results is high at the timer-1 edge, all four result words keep the values they held before.
- R5: Both counters are zeroed at the timer-3 edge of every period, including periods whose results were held. Each published total therefore covers exactly one period's window.
- R6: A counter that reaches all ones stays at all ones until it is cleared. It does not wrap.
- R7: Each input passes through a two-flop synchroniser. Each low-to-high transition is counted exactly once, at the third clock edge after the first edge that samples the input high.
- R8: While rst_n is low at a clock edge, the timer, the counters, the gate controls and all result words return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the timer and all state run on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Prescaled oscillator signal, asynchronous |
| ext_in | input | 1 | External reference signal, asynchronous |
| hold_results | input | 1 | High keeps the published words unchanged at the publish edge |
| osc_hi | output | HALF_W | Upper half of the oscillator channel total |
| osc_lo | output | HALF_W | Lower half of the oscillator channel total |
| ext_hi | output | HALF_W | Upper half of the external channel total |
| ext_lo | output | HALF_W | Lower half of the external channel total |

## Verification
The result words are the only window into this block, so any fault inside it shows up after a delay of one gate period. A timer that wraps at the wrong count, or a publish at the wrong step, moves the update edge. Checks made one cycle before and one cycle after the expected update catch that shift. A gate that opens or closes one step off either counts pulses placed just outside the window or drops pulses placed on its last edge. Both show in the very next published total. A missed clear shows as accumulation in the period after a held one. A wrapping counter shows as a small total instead of all ones, in a narrow configuration.

// File: rtl/fgc_pkg.sv
// Package: shared step numbers and control bundle for the gated frequency counter.
// Assumes the gate timer starts at zero and visits every step once per period.
package fgc_pkg;
    // Timer values at which the fixed gate sequence acts; the order is behaviour.
    localparam int STEP_STOP    = 0;
    localparam int STEP_PUBLISH = 1;
    localparam int STEP_CLR_ON  = 2;
    localparam int STEP_CLR_OFF = 3;
    localparam int STEP_RUN     = 4;

    // Number of counted channels.
    localparam int NUM_CH = 2;

    // Controls the sequencer hands to the counters and result registers.
    typedef struct packed {
        logic count_en;
        logic clear;
        logic publish;
    } gate_ctl_t;
endpackage

// File: rtl/fgc_gate_seq.sv
// Module: gate timer and stop/publish/clear/run sequencer.
// Counts clk cycles 0..GATE_LAST and drives the gate controls from the
// timer value. Assumes GATE_LAST >= 6 so the sequence fits in one period.
module fgc_gate_seq
    import fgc_pkg::*;
#(
    parameter int GATE_LAST = 24000005
) (
    input  logic      clk,
    input  logic      rst_n,
    output gate_ctl_t ctl
);
    localparam int TMR_W = $clog2(GATE_LAST + 1);
    localparam logic [TMR_W-1:0] LAST_T  = TMR_W'(GATE_LAST);
    localparam logic [TMR_W-1:0] T_STOP  = TMR_W'(STEP_STOP);
    localparam logic [TMR_W-1:0] T_PUB   = TMR_W'(STEP_PUBLISH);
    localparam logic [TMR_W-1:0] T_CLON  = TMR_W'(STEP_CLR_ON);
    localparam logic [TMR_W-1:0] T_CLOFF = TMR_W'(STEP_CLR_OFF);
    localparam logic [TMR_W-1:0] T_RUN   = TMR_W'(STEP_RUN);

    logic [TMR_W-1:0] tmr;
    logic             en_q;
    logic             clr_q;

    // Free-running period timer with wrap at GATE_LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)              tmr <= '0;
        else if (tmr == LAST_T)  tmr <= '0;
        else                     tmr <= tmr + 1'b1;
    end

    // Count-enable: dropped at the stop step, raised again at the run step.
    always_ff @(posedge clk) begin
        if (!rst_n)               en_q <= 1'b0;
        else if (tmr == T_STOP)   en_q <= 1'b0;
        else if (tmr == T_RUN)    en_q <= 1'b1;
    end

    // Counter clear: raised at the clear step, released at the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)               clr_q <= 1'b0;
        else if (tmr == T_CLON)   clr_q <= 1'b1;
        else if (tmr == T_CLOFF)  clr_q <= 1'b0;
    end

    // Bundle outputs; publish is a one-cycle strobe at the publish step.
    always_comb begin
        ctl.count_en = en_q;
        ctl.clear    = clr_q;
        ctl.publish  = (tmr == T_PUB);
    end

    // R1: the timer wraps to zero after its last value.
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr == LAST_T) |=> (tmr == '0));
    // R1: below the last value the timer advances by exactly one.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr != LAST_T) |=> (tmr == $past(tmr) + 1'b1));
    // R2: the gate is shut from the publish step through the run step.
    a_r2_gate_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr >= T_PUB && tmr <= T_RUN) |-> !en_q);
    // R5: the clear is seen only while the timer reads the release step.
    a_r5_clear_slot: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> (tmr == T_CLOFF));
endmodule

// File: rtl/fgc_edge_sync.sv
// Module: two-flop synchroniser with rising-edge detect.
// Assumes the input holds each level for at least one clk cycle;
// produces a one-cycle strike per low-to-high transition.
module fgc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    // Two-stage capture of the asynchronous level plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Edge strike from the synchronised level and its delayed copy.
    assign rise = sync_q & ~last_q;

    // R7: a strike lasts one cycle only.
    a_r7_single_strike: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fgc_sat_counter.sv
// Module: saturating event counter with synchronous clear.
// Clear has priority over counting; counts strikes only while enabled.
module fgc_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             strike,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic at_top;
    assign at_top = (count == ALL_ONES);

    // Count strikes while the gate is open; stop at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                         count <= '0;
        else if (clear)                     count <= '0;
        else if (enable && strike && !at_top) count <= count + 1'b1;
    end

    // R6: a full counter stays full until cleared.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && !clear) |=> (count == ALL_ONES));
    // R5: a clear leaves the counter at zero.
    a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
    // R2: with the gate shut and no clear, the count does not move.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(count));
endmodule

// File: rtl/fgc_result_reg.sv
// Module: published result words for one channel.
// Loads the split count on the publish strobe unless hold is high.
module fgc_result_reg #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                publish,
    input  logic                hold,
    input  logic [2*HALF_W-1:0] count,
    output logic [HALF_W-1:0]   word_hi,
    output logic [HALF_W-1:0]   word_lo
);
    // Capture the two halves of the count at the publish step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_hi <= '0;
            word_lo <= '0;
        end else if (publish && !hold) begin
            word_hi <= count[2*HALF_W-1:HALF_W];
            word_lo <= count[HALF_W-1:0];
        end
    end

    // R4: a held publish leaves both words untouched.
    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (publish && hold) |=> ($stable(word_hi) && $stable(word_lo)));
    // R1: outside the publish strobe the words never change.
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> ($stable(word_hi) && $stable(word_lo)));
endmodule

// File: rtl/freq_gate_meter.sv
// Module: top of the gated dual-channel frequency counter.
// Channel 0 is the prescaled oscillator, channel 1 the external reference.
// Assumes both inputs are slower than clk/2 with levels of >= 1 cycle.
module freq_gate_meter
    import fgc_pkg::*;
#(
    parameter int GATE_LAST = 24000005,
    parameter int HALF_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              ext_in,
    input  logic              hold_results,
    output logic [HALF_W-1:0] osc_hi,
    output logic [HALF_W-1:0] osc_lo,
    output logic [HALF_W-1:0] ext_hi,
    output logic [HALF_W-1:0] ext_lo
);
    localparam int CNT_W = 2 * HALF_W;

    gate_ctl_t         ctl;
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] strike;
    logic [CNT_W-1:0]  count [NUM_CH];
    logic [HALF_W-1:0] res_hi [NUM_CH];
    logic [HALF_W-1:0] res_lo [NUM_CH];

    assign raw_in = {ext_in, osc_in};

    fgc_gate_seq #(.GATE_LAST(GATE_LAST)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl)
    );

    // One synchroniser, counter and result register per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        fgc_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[ch]),
            .rise     (strike[ch])
        );

        fgc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (ctl.clear),
            .enable (ctl.count_en),
            .strike (strike[ch]),
            .count  (count[ch])
        );

        fgc_result_reg #(.HALF_W(HALF_W)) u_res (
            .clk     (clk),
            .rst_n   (rst_n),
            .publish (ctl.publish),
            .hold    (hold_results),
            .count   (count[ch]),
            .word_hi (res_hi[ch]),
            .word_lo (res_lo[ch])
        );
    end

    assign osc_hi = res_hi[0];
    assign osc_lo = res_lo[0];
    assign ext_hi = res_hi[1];
    assign ext_lo = res_lo[1];

    // R3: an unheld publish copies the live count into the words.
    a_r3_publish_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.publish && !hold_results) |=> ({osc_hi, osc_lo} == $past(count[0])));
endmodule

// File: tb/tb_freq_gate_meter.sv
// Bench: vector table walked period by period, then directed window-edge,
// saturation and reset checks. Main instance uses a 200-cycle period,
// the saturation instance an 800-cycle period with 8-bit counters.
module tb_freq_gate_meter;
    localparam int PER_A = 200;
    localparam int PER_B = 800;
    localparam int NV    = 9;

    typedef struct packed {
        logic [7:0]  osc_n;
        logic [7:0]  ext_n;
        logic        hold;
        logic [31:0] osc_exp;
        logic [31:0] ext_exp;
    } vec_t;

    // Pulses driven in period i; hold applies at the next publish; expected words.
    localparam vec_t TAB [NV] = '{
        '{8'd3,  8'd5,  1'b0, 32'd3,  32'd5},
        '{8'd0,  8'd0,  1'b0, 32'd0,  32'd0},
        '{8'd10, 8'd1,  1'b0, 32'd10, 32'd1},
        '{8'd7,  8'd7,  1'b1, 32'd10, 32'd1},
        '{8'd2,  8'd9,  1'b0, 32'd2,  32'd9},
        '{8'd40, 8'd33, 1'b0, 32'd40, 32'd33},
        '{8'd4,  8'd0,  1'b1, 32'd40, 32'd33},
        '{8'd4,  8'd0,  1'b1, 32'd40, 32'd33},
        '{8'd1,  8'd2,  1'b0, 32'd1,  32'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_in = 1'b0, ext_in = 1'b0, hold_results = 1'b0;
    logic        sat_osc = 1'b0, sat_ext = 1'b0, sat_hold = 1'b0;
    logic [15:0] osc_hi, osc_lo, ext_hi, ext_lo;
    logic [3:0]  s_osc_hi, s_osc_lo, s_ext_hi, s_ext_lo;
    int          edges = 0;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    // Bench-side edge index since reset release.
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    freq_gate_meter #(.GATE_LAST(PER_A - 1), .HALF_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ext_in(ext_in),
        .hold_results(hold_results),
        .osc_hi(osc_hi), .osc_lo(osc_lo), .ext_hi(ext_hi), .ext_lo(ext_lo)
    );

    freq_gate_meter #(.GATE_LAST(PER_B - 1), .HALF_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .osc_in(sat_osc), .ext_in(sat_ext),
        .hold_results(sat_hold),
        .osc_hi(s_osc_hi), .osc_lo(s_osc_lo), .ext_hi(s_ext_hi), .ext_lo(s_ext_lo)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R8: reset state of the result words.
        chk("R8 reset osc", {osc_hi, osc_lo}, 32'd0);
        chk("R8 reset ext", {ext_hi, ext_lo}, 32'd0);

        // Table walk: R3 publish, R4 hold, R5 clear per period, R7 per-pulse counting.
        for (int i = 0; i < NV; i++) begin
            int n;
            hold_results = (i > 0) ? TAB[i-1].hold : 1'b0;
            tick(3);
            if (i > 0) begin
                chk($sformatf("R3/R4/R5 vec%0d osc", i - 1), {osc_hi, osc_lo}, TAB[i-1].osc_exp);
                chk($sformatf("R3/R4/R5/R7 vec%0d ext", i - 1), {ext_hi, ext_lo}, TAB[i-1].ext_exp);
            end
            tick(17);
            n = (TAB[i].osc_n > TAB[i].ext_n) ? int'(TAB[i].osc_n) : int'(TAB[i].ext_n);
            for (int j = 0; j < n; j++) begin
                osc_in = (j < int'(TAB[i].osc_n));
                ext_in = (j < int'(TAB[i].ext_n));
                tick(2);
                osc_in = 1'b0;
                ext_in = 1'b0;
                tick(2);
            end
            tick(PER_A - 20 - 4 * n);
        end

        // Directed window edges: R2 closed gate at step 4, open at step 0.
        hold_results = TAB[NV-1].hold;
        tick(2);
        osc_in = 1'b1;           // strike lands on the step-4 edge: lost
        tick(1);
        chk("R3 last vec osc", {osc_hi, osc_lo}, TAB[NV-1].osc_exp);
        tick(1);
        osc_in = 1'b0;
        tick(96);
        osc_in = 1'b1;           // mid-window pulse: counted
        tick(2);
        osc_in = 1'b0;
        tick(96);
        ext_in = 1'b1;           // strike lands on the step-0 edge: counted
        tick(2);
        ext_in = 1'b0;
        tick(1);
        // R1: one cycle before the publish edge the old words remain.
        chk("R1 before publish", {osc_hi, osc_lo}, TAB[NV-1].osc_exp);
        tick(1);
        chk("R2 gate closed at step 4", {osc_hi, osc_lo}, 32'd1);
        chk("R2 gate open at step 0", {ext_hi, ext_lo}, 32'd1);

        // R6: saturation in the narrow instance; R3 split into halves.
        while ((edges % PER_B) != 20) tick(1);
        for (int j = 0; j < 300; j++) begin
            sat_osc = 1'b1;
            sat_ext = (j < 100);
            tick(1);
            sat_osc = 1'b0;
            sat_ext = 1'b0;
            tick(1);
        end
        while ((edges % PER_B) != 3) tick(1);
        chk("R6 saturate at all ones", {24'd0, s_osc_hi, s_osc_lo}, 32'h0000_00FF);
        chk("R3 high/low split", {24'd0, s_ext_hi, s_ext_lo}, 32'h0000_0064);

        // R8: reset in mid-run clears published words.
        rst_n = 1'b0;
        tick(2);
        chk("R8 mid-run reset sat", {24'd0, s_osc_hi, s_osc_lo}, 32'd0);
        chk("R8 mid-run reset main", {ext_hi, ext_lo}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule